// File: doc/BRIEF.md
# Fixed-Mapping Segment Address Translator

This block turns a 32-bit virtual address into a physical address for a core that has no translation lookaside buffer, or whose buffer sits elsewhere. A two-bit MMU-kind code, taken from the core's configuration register, selects the behaviour. Identity mode passes the address straight through. Fixed mode applies a small set of segment rules: the low half of the address space is shifted up by 1 GiB unless the error-level status bit is set, the window from 0x80000000 to 0xBFFFFFFF loses its top three bits, and the rest passes unchanged.

When the code selects TLB mode, the block translates only the directly mapped kernel window itself. For every other address it raises a lookup request so that an external TLB can take over. The fourth code is reserved, and the block reports it on an error flag.

The translation is purely combinational. A parameter can add one register stage on the outputs, and that register clears on an active-low reset. Privilege checking and address-error exceptions belong to other logic.

Top module: `seg_xlat_top`

## Requirements
- R1: With MMU-kind code 0 (identity), `paddr` equals `vaddr`. `can_read`, `can_write` and `hit` are 1, and `tlb_req` and `kind_err` are 0.
- R2: With code 3 (fixed), an address in 0x00000000..0x7FFFFFFF with `err_level`=0 maps to `vaddr` + 0x40000000, with read, write and hit all set.
- R3: With code 3, an address in 0x00000000..0x7FFFFFFF with `err_level`=1 maps to itself.
- R4: With code 3 or code 1, an address in 0x80000000..0xBFFFFFFF maps to `vaddr` & 0x1FFFFFFF, with read, write and hit all set.
- R5: With code 3, an address of 0xC0000000 or above maps to itself, with read, write and hit all set.
- R6: With code 1 (TLB), an address below 0x80000000 or at 0xC0000000 and above gives `tlb_req`=1, `hit`=0, no read or write permission, and `paddr`=0.
- R7: At most one of `hit`, `tlb_req` and `kind_err` is 1. `can_read` and `can_write` always equal `hit`.
- R8: Code 2 is reserved. It gives `kind_err`=1, `paddr`=0, and `hit`, `tlb_req`, `can_read` and `can_write` all 0.
- R9: `err_level` has no effect in code 0. In code 3 it has no effect on addresses at 0x80000000 or above.
- R10: With `REG_OUT`=1, each output reflects the inputs of the previous rising clock edge, and all outputs are 0 while `rst_n` is low. With `REG_OUT`=0, the outputs follow the inputs in the same cycle.
- R11: Region limits use unsigned comparison. 0x7FFFFFFF is a user address, 0x80000000 and 0xBFFFFFFF belong to the direct kernel window, and 0xC0000000 is in the upper region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, clears the output register |
| vaddr | input | 32 | Virtual address |
| err_level | input | 1 | Error-level status bit, suppresses the user-segment offset |
| mmu_kind | input | 2 | MMU-kind code: 0 identity, 1 TLB, 2 reserved, 3 fixed |
| paddr | output | 32 | Physical address |
| can_read | output | 1 | Read permitted |
| can_write | output | 1 | Write permitted |
| hit | output | 1 | Translation resolved by this block |
| tlb_req | output | 1 | Address must be looked up in an external TLB |
| kind_err | output | 1 | Reserved MMU-kind code in use |

## Verification
The bench builds two copies of the block from the same stimulus: one with `REG_OUT`=1 and one with `REG_OUT`=0, both with the default 32-bit address width. The combinational copy allows each mapping rule to be checked within the cycle the inputs are applied. The registered copy brings the one-edge delay and the cleared reset state within reach. Comparing the two copies one instant before an edge shows that the registered outputs still hold the previous translation.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    // MMU-kind codes as carried by the configuration field
    typedef enum logic [1:0] {
        MK_IDENT = 2'd0,
        MK_TLB   = 2'd1,
        MK_RSVD  = 2'd2,
        MK_FIXED = 2'd3
    } mmu_kind_e;

    // Address regions, decoded from the two top address bits
    typedef enum logic [1:0] {
        RG_USER    = 2'd0,
        RG_KDIRECT = 2'd1,
        RG_KHIGH   = 2'd2
    } region_e;

endpackage

// File: rtl/seg_region_dec.sv
module seg_region_dec
    import seg_xlat_pkg::*;
(
    input  logic [1:0] va_top,
    output region_e    region
);

    always_comb begin
        if (!va_top[1]) begin
            region = RG_USER;
        end else if (!va_top[0]) begin
            region = RG_KDIRECT;
        end else begin
            region = RG_KHIGH;
        end
    end

endmodule

// File: rtl/seg_map_core.sv
module seg_map_core
    import seg_xlat_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] va,
    input  logic              err_level,
    input  mmu_kind_e         kind,
    input  region_e           region,
    output logic [ADDR_W-1:0] pa,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              hit,
    output logic              tlb_req,
    output logic              kind_err
);

    // 1/4 of the address space and the mask that strips the top three bits
    localparam logic [ADDR_W-1:0] USER_OFFS = {2'b01, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] KDIR_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

    logic [ADDR_W-1:0] fixed_pa;

    always_comb begin
        case (region)
            RG_USER:    fixed_pa = err_level ? va : (va + USER_OFFS);
            RG_KDIRECT: fixed_pa = va & KDIR_MASK;
            default:    fixed_pa = va;
        endcase
    end

    always_comb begin
        pa       = '0;
        rd_ok    = 1'b0;
        wr_ok    = 1'b0;
        hit      = 1'b0;
        tlb_req  = 1'b0;
        kind_err = 1'b0;
        unique case (kind)
            MK_IDENT: begin
                pa    = va;
                rd_ok = 1'b1;
                wr_ok = 1'b1;
                hit   = 1'b1;
            end
            MK_FIXED: begin
                pa    = fixed_pa;
                rd_ok = 1'b1;
                wr_ok = 1'b1;
                hit   = 1'b1;
            end
            MK_TLB: begin
                if (region == RG_KDIRECT) begin
                    pa    = va & KDIR_MASK;
                    rd_ok = 1'b1;
                    wr_ok = 1'b1;
                    hit   = 1'b1;
                end else begin
                    tlb_req = 1'b1;
                end
            end
            MK_RSVD: begin
                kind_err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
    import seg_xlat_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter bit REG_OUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] vaddr,
    input  logic              err_level,
    input  logic [1:0]        mmu_kind,
    output logic [ADDR_W-1:0] paddr,
    output logic              can_read,
    output logic              can_write,
    output logic              hit,
    output logic              tlb_req,
    output logic              kind_err
);

    localparam int FLAG_W = 5;
    localparam int BUS_W  = ADDR_W + FLAG_W;

    region_e           region;
    logic [ADDR_W-1:0] pa_c;
    logic              rd_c, wr_c, hit_c, tlb_c, err_c;
    logic [BUS_W-1:0]  bus_c;
    logic [BUS_W-1:0]  bus_q;

    seg_region_dec u_dec (
        .va_top (vaddr[ADDR_W-1 -: 2]),
        .region (region)
    );

    seg_map_core #(.ADDR_W(ADDR_W)) u_core (
        .va        (vaddr),
        .err_level (err_level),
        .kind      (mmu_kind_e'(mmu_kind)),
        .region    (region),
        .pa        (pa_c),
        .rd_ok     (rd_c),
        .wr_ok     (wr_c),
        .hit       (hit_c),
        .tlb_req   (tlb_c),
        .kind_err  (err_c)
    );

    assign bus_c = {pa_c, rd_c, wr_c, hit_c, tlb_c, err_c};

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bus_q <= '0;
                end else begin
                    bus_q <= bus_c;
                end
            end

            // R10
            lat_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (kind_err == ($past(mmu_kind) == 2'd2)));

            // R4
            lat_kdir_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(mmu_kind) == 2'd3 &&
                 $past(vaddr[ADDR_W-1 -: 2]) == 2'b10)
                |-> (paddr[ADDR_W-1 -: 3] == 3'b000 && hit));
        end else begin : g_comb
            assign bus_q = bus_c;

            // R8
            comb_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
                kind_err == (mmu_kind == 2'd2));

            // R4
            comb_kdir_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mmu_kind[0] && vaddr[ADDR_W-1 -: 2] == 2'b10)
                |-> (paddr[ADDR_W-1 -: 3] == 3'b000 && hit));
        end
    endgenerate

    assign {paddr, can_read, can_write, hit, tlb_req, kind_err} = bus_q;

    // R7
    excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit, tlb_req, kind_err}));

    // R7
    perm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (can_read == hit) && (can_write == hit));

    // R8
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kind_err |-> (paddr == '0 && !tlb_req));

    // R6
    tlb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req |-> (paddr == '0));

endmodule

// File: tb/sim_seg_xlat_top.sv
`timescale 1ns/1ps
module sim_seg_xlat_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] vaddr = 32'h1234_5678;
    logic        err_level = 1'b0;
    logic [1:0]  mmu_kind = 2'd0;

    logic [31:0] pa0, pa1;
    logic        r0, w0, h0, t0, e0;
    logic        r1, w1, h1, t1, e1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    seg_xlat_top #(.ADDR_W(32), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .err_level(err_level),
        .mmu_kind(mmu_kind), .paddr(pa0), .can_read(r0), .can_write(w0),
        .hit(h0), .tlb_req(t0), .kind_err(e0)
    );

    seg_xlat_top #(.ADDR_W(32), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .err_level(err_level),
        .mmu_kind(mmu_kind), .paddr(pa1), .can_read(r1), .can_write(w1),
        .hit(h1), .tlb_req(t1), .kind_err(e1)
    );

    // expected bundle {paddr, rd, wr, hit, tlb_req, kind_err}
    function automatic logic [36:0] model(input logic [31:0] va, input logic el,
                                          input logic [1:0] k);
        logic [31:0] p;
        case (k)
            2'd0: return {va, 5'b11100};
            2'd2: return {32'h0, 5'b00001};
            2'd1: begin
                if (va >= 32'h8000_0000 && va <= 32'hBFFF_FFFF)
                    return {va & 32'h1FFF_FFFF, 5'b11100};
                return {32'h0, 5'b00010};
            end
            default: begin
                if (va <= 32'h7FFF_FFFF) p = el ? va : va + 32'h4000_0000;
                else if (va <= 32'hBFFF_FFFF) p = va & 32'h1FFF_FFFF;
                else p = va;
                return {p, 5'b11100};
            end
        endcase
    endfunction

    task automatic check(input string tag, input logic [36:0] act, input logic [36:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // apply inputs, check combinational copy, then registered copy after the edge
    task automatic run(input string tag, input logic [31:0] va, input logic el,
                       input logic [1:0] k);
        logic [36:0] exp;
        @(negedge clk);
        vaddr = va; err_level = el; mmu_kind = k;
        exp = model(va, el, k);
        #1;
        check({tag, " comb"}, {pa1, r1, w1, h1, t1, e1}, exp);
        @(posedge clk);
        #1;
        check({tag, " reg"}, {pa0, r0, w0, h0, t0, e0}, exp);
    endtask

    task automatic t_reset;
        @(posedge clk); #1;
        check("R10 reset clears", {pa0, r0, w0, h0, t0, e0}, 37'h0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_identity;
        run("R1 ident low", 32'h0000_1000, 1'b0, 2'd0);
        run("R1 ident high", 32'hF00D_BEEF, 1'b0, 2'd0);
        run("R1 ident kdir", 32'h9ABC_DEF0, 1'b0, 2'd0);
    endtask

    task automatic t_fixed_user;
        run("R2 user offset", 32'h0012_3450, 1'b0, 2'd3);
        run("R2 user top", 32'h7000_0004, 1'b0, 2'd3);
        run("R3 user errlvl", 32'h0012_3450, 1'b1, 2'd3);
        run("R3 user errlvl hi", 32'h7FFF_0000, 1'b1, 2'd3);
    endtask

    task automatic t_fixed_kernel;
        run("R4 kseg0", 32'h8000_4000, 1'b0, 2'd3);
        run("R4 kseg1", 32'hA1F0_0010, 1'b0, 2'd3);
        run("R5 kseg2", 32'hC000_1234, 1'b0, 2'd3);
        run("R5 kseg3", 32'hFFFF_FFFC, 1'b0, 2'd3);
    endtask

    task automatic t_tlb_mode;
        run("R6 tlb user", 32'h0040_0000, 1'b0, 2'd1);
        run("R6 tlb khigh", 32'hE000_0000, 1'b1, 2'd1);
        run("R4 tlb kdirect", 32'hBFC0_0000, 1'b0, 2'd1);
        run("R7 tlb kdirect el", 32'h8123_4567, 1'b1, 2'd1);
    endtask

    task automatic t_reserved;
        run("R8 rsvd user", 32'h0000_0100, 1'b0, 2'd2);
        run("R8 rsvd kdir", 32'h8000_0000, 1'b1, 2'd2);
    endtask

    task automatic t_ignore_level;
        run("R9 ident el", 32'h0000_2000, 1'b1, 2'd0);
        run("R9 fixed kdir el", 32'hB000_0040, 1'b1, 2'd3);
        run("R9 fixed khigh el", 32'hD000_0040, 1'b1, 2'd3);
    endtask

    task automatic t_bounds;
        run("R11 7FFFFFFF", 32'h7FFF_FFFF, 1'b0, 2'd3);
        run("R11 80000000", 32'h8000_0000, 1'b0, 2'd3);
        run("R11 BFFFFFFF", 32'hBFFF_FFFF, 1'b0, 2'd3);
        run("R11 C0000000", 32'hC000_0000, 1'b0, 2'd3);
        run("R11 tlb 7FFFFFFF", 32'h7FFF_FFFF, 1'b0, 2'd1);
        run("R11 tlb C0000000", 32'hC000_0000, 1'b0, 2'd1);
    endtask

    task automatic t_latency;
        logic [36:0] old_exp;
        logic [36:0] new_exp;
        run("R10 prime", 32'h0000_0800, 1'b0, 2'd3);
        old_exp = model(32'h0000_0800, 1'b0, 2'd3);
        new_exp = model(32'h9000_0800, 1'b0, 2'd3);
        @(negedge clk);
        vaddr = 32'h9000_0800;
        #1;
        check("R10 reg holds old", {pa0, r0, w0, h0, t0, e0}, old_exp);
        check("R10 comb same cycle", {pa1, r1, w1, h1, t1, e1}, new_exp);
        @(posedge clk); #1;
        check("R10 reg after edge", {pa0, r0, w0, h0, t0, e0}, new_exp);
    endtask

    initial begin
        t_reset;
        t_identity;
        t_fixed_user;
        t_fixed_kernel;
        t_tlb_mode;
        t_reserved;
        t_ignore_level;
        t_bounds;
        t_latency;
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule